// File: doc/BRIEF.md
# Serial Transmit Channel with Handshake Flags

This block sends bytes on a single serial line in asynchronous form: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Each bit lasts a parameterised number of baud-tick enables. A host writes a byte into a holding register and then clears a "holding register empty" flag. That clear is what releases the byte. The flag returns to 1 when the byte is copied into the shift register at a bit boundary, so the host can write the next byte while the current one is on the wire. A second write port, meant for a transfer engine that reacts to the interrupt request, writes the byte and clears the flag in the same cycle.

When the transmit enable goes high, the channel takes over the pin and first sends one full frame time of marking (all 1) bits. Only after that can a data frame start. A "transmit finished" flag reports that the last frame has fully left the shift register and that nothing is waiting. When transmit enable is low, the pin belongs to a general-purpose port bit. If that bit is an output driven low, the line shows a break.

The control state machine has six states:
- IDLE_OFF: disabled.
- MARK_FRAME: the marking frame sent after enable.
- WAIT_DATA: marking, waiting for data.
- START_BIT, DATA_BITS, STOP_BIT: one data frame.

Transitions:
- OFF→MARK when enable is seen.
- MARK→WAIT or MARK→START at the end of the tenth marking bit.
- WAIT→START at a bit boundary with data pending.
- START→DATA after one bit time.
- DATA→STOP after eight bits.
- STOP→START (back-to-back) or STOP→WAIT.
- Any state→OFF when enable is low.

Top module: `sertx_chan`

## Requirements
- R1: After reset, with tx_en low and port_dir low: txd is 1, empty_flag is 1, end_flag is 1 and txi_req is 0.
- R2: When tx_en rises, txd stays 1 for ten bit times (10 x BIT_TICKS baud ticks, counted from the first tick after enable) before any start bit can appear.
- R3: A pulse on wr_data_en alone loads the holding register but starts no frame: empty_flag stays 1 and txd stays 1.
- R4: A clr_empty pulse sets empty_flag to 0. At the next bit boundary the held byte moves into the shift register. In that same cycle empty_flag returns to 1 and txd goes to 0 (start bit).
- R5: A frame is one start bit of 0, then eight data bits with bit 0 first, then one stop bit of 1. Each bit lasts BIT_TICKS baud ticks.
- R6: txi_req is 1 exactly when empty_flag is 1 and tx_en is 1.
- R7: A dma_wr pulse writes wr_data to the holding register and clears empty_flag in the same cycle. No separate clear is needed.
- R8: end_flag becomes 1 at the end of a stop bit when no byte is pending. If a byte is pending, the next start bit follows the stop bit directly and end_flag stays 0.
- R9: A clr_empty or dma_wr pulse clears end_flag while tx_en is 1.
- R10: Dropping tx_en in the middle of a frame abandons the frame at once and holds end_flag at 1 while disabled. Raising tx_en again restarts with the marking frame.
- R11: While tx_en is 1, txd carries the transmitter output whatever the port bits are. While tx_en is 0, txd equals port_val if port_dir is 1, and 1 otherwise.
- R12: With port_dir 1 and port_val 0, clearing tx_en drives txd to 0 and keeps it there (break).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle baud enable |
| tx_en | input | 1 | Transmit enable, also takes the pin |
| wr_data_en | input | 1 | Host write strobe for the holding register |
| dma_wr | input | 1 | Engine write: load holding register and clear the empty flag |
| clr_empty | input | 1 | Host strobe that clears the empty flag |
| wr_data | input | 8 | Byte for either write strobe |
| port_dir | input | 1 | General-purpose port direction, 1 = output |
| port_val | input | 1 | General-purpose port output value |
| txd | output | 1 | Serial line |
| empty_flag | output | 1 | Holding register may be written |
| end_flag | output | 1 | Transmission finished |
| txi_req | output | 1 | Holding-register-empty interrupt request |

## Verification
The bench drives several edge cases.
- A write with no clear: a design that started on the write alone would put a start bit on the line.
- A clear issued right after enable: a design that skipped the marking frame would start the data too early.
- Back-to-back engine writes: a design with a gap after the stop bit, or one that raised end_flag between frames, would show the wrong line value or flag in that cycle.
- Disabling in mid-frame, then a port-driven break: a design that kept the frame running or failed to hand the pin to the port would leave txd at the transmitter's level instead of the port's.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_MARK  = 3'd1,
        S_IDLE  = 3'd2,
        S_START = 3'd3,
        S_DATA  = 3'd4,
        S_STOP  = 3'd5
    } tx_state_t;

    localparam int unsigned FRAME_OVERHEAD = 2;

endpackage

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int unsigned BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic baud_tick,
    output logic bit_end
);
    localparam int unsigned CW = (BIT_TICKS > 1) ? $clog2(BIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(BIT_TICKS - 1);

    logic [CW-1:0] tick_cnt;

    // A bit ends on the baud tick that completes its tick count
    assign bit_end = !hold && baud_tick && (tick_cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
        end else if (hold) begin
            tick_cnt <= '0;
        end else if (baud_tick) begin
            tick_cnt <= (tick_cnt == LAST) ? '0 : tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int unsigned DATA_BITS = 8,
    parameter int unsigned MARK_BITS = 10
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tx_en,
    input  logic      bit_end,
    input  logic      pending,
    output tx_state_t state,
    output logic      load,
    output logic      end_set,
    output logic      shift_step,
    output logic      timer_hold
);
    localparam int unsigned MAXB = (MARK_BITS > DATA_BITS) ? MARK_BITS : DATA_BITS;
    localparam int unsigned CNTW = $clog2(MAXB + 1);
    localparam logic [CNTW-1:0] MARK_LAST = CNTW'(MARK_BITS - 1);
    localparam logic [CNTW-1:0] DATA_LAST = CNTW'(DATA_BITS - 1);

    tx_state_t     state_q, state_d;
    logic [CNTW-1:0] bit_cnt;
    logic          frame_edge;

    // Bit boundary at which a new frame may begin
    always_comb begin
        frame_edge = 1'b0;
        unique case (state_q)
            S_MARK:  frame_edge = bit_end && (bit_cnt == MARK_LAST);
            S_IDLE:  frame_edge = bit_end;
            S_STOP:  frame_edge = bit_end;
            default: frame_edge = 1'b0;
        endcase
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (!tx_en) begin
            state_d = S_OFF;
        end else begin
            unique case (state_q)
                S_OFF:   state_d = S_MARK;
                S_MARK:  if (frame_edge) state_d = pending ? S_START : S_IDLE;
                S_IDLE:  if (frame_edge && pending) state_d = S_START;
                S_START: if (bit_end) state_d = S_DATA;
                S_DATA:  if (bit_end && (bit_cnt == DATA_LAST)) state_d = S_STOP;
                S_STOP:  if (frame_edge) state_d = pending ? S_START : S_IDLE;
                default: state_d = S_OFF;
            endcase
        end
    end

    // State register and bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
            bit_cnt <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                bit_cnt <= '0;
            end else if (bit_end) begin
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        load       = 1'b0;
        end_set    = 1'b0;
        shift_step = 1'b0;
        timer_hold = 1'b0;
        unique case (state_q)
            S_OFF:   timer_hold = 1'b1;
            S_MARK,
            S_IDLE:  load = tx_en && frame_edge && pending;
            S_START: ;
            S_DATA:  shift_step = tx_en && bit_end;
            S_STOP: begin
                load    = tx_en && frame_edge && pending;
                end_set = tx_en && frame_edge && !pending;
            end
            default: timer_hold = 1'b1;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 step,
    input  logic [DATA_BITS-1:0] par_in,
    output logic                 ser_bit
);
    logic [DATA_BITS-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (load) begin
            sreg <= par_in;
        end else if (step) begin
            sreg <= {1'b0, sreg[DATA_BITS-1:1]};
        end
    end

    assign ser_bit = sreg[0];

endmodule

// File: rtl/sertx_flags.sv
module sertx_flags #(
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_en,
    input  logic                 wr_data_en,
    input  logic                 dma_wr,
    input  logic                 clr_empty,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 load,
    input  logic                 end_set,
    output logic [DATA_BITS-1:0] hold_reg,
    output logic                 empty_q,
    output logic                 end_q
);
    logic clear_req;

    assign clear_req = clr_empty || dma_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_reg <= '0;
        end else if (wr_data_en || dma_wr) begin
            hold_reg <= wr_data;
        end
    end

    // A copy into the shift register only happens while empty_q is 0,
    // so it never competes with a legitimate clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
        end else if (load) begin
            empty_q <= 1'b1;
        end else if (clear_req) begin
            empty_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            end_q <= 1'b1;
        end else if (!tx_en || end_set) begin
            end_q <= 1'b1;
        end else if (clear_req) begin
            end_q <= 1'b0;
        end
    end

endmodule

// File: rtl/sertx_chan.sv
module sertx_chan
    import sertx_pkg::*;
#(
    parameter int unsigned BIT_TICKS = 16,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 tx_en,
    input  logic                 wr_data_en,
    input  logic                 dma_wr,
    input  logic                 clr_empty,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 port_dir,
    input  logic                 port_val,
    output logic                 txd,
    output logic                 empty_flag,
    output logic                 end_flag,
    output logic                 txi_req
);
    localparam int unsigned MARK_BITS = DATA_BITS + FRAME_OVERHEAD;

    tx_state_t            state;
    logic                 bit_end, load, end_set, shift_step, timer_hold;
    logic                 ser_bit, line_bit, empty_q, end_q;
    logic [DATA_BITS-1:0] hold_reg;

    sertx_bit_timer #(.BIT_TICKS(BIT_TICKS)) timer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (timer_hold),
        .baud_tick (baud_tick),
        .bit_end   (bit_end)
    );

    sertx_ctrl #(.DATA_BITS(DATA_BITS), .MARK_BITS(MARK_BITS)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .bit_end    (bit_end),
        .pending    (!empty_q),
        .state      (state),
        .load       (load),
        .end_set    (end_set),
        .shift_step (shift_step),
        .timer_hold (timer_hold)
    );

    sertx_shifter #(.DATA_BITS(DATA_BITS)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (shift_step),
        .par_in  (hold_reg),
        .ser_bit (ser_bit)
    );

    sertx_flags #(.DATA_BITS(DATA_BITS)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .wr_data_en (wr_data_en),
        .dma_wr     (dma_wr),
        .clr_empty  (clr_empty),
        .wr_data    (wr_data),
        .load       (load),
        .end_set    (end_set),
        .hold_reg   (hold_reg),
        .empty_q    (empty_q),
        .end_q      (end_q)
    );

    // Transmitter line level per state
    always_comb begin
        unique case (state)
            S_START: line_bit = 1'b0;
            S_DATA:  line_bit = ser_bit;
            default: line_bit = 1'b1;
        endcase
    end

    // Pin ownership: transmitter when enabled, otherwise the port bit
    always_comb begin
        if (tx_en) begin
            txd = line_bit;
        end else if (port_dir) begin
            txd = port_val;
        end else begin
            txd = 1'b1;
        end
    end

    assign empty_flag = empty_q;
    assign end_flag   = end_q;
    assign txi_req    = empty_q && tx_en;

endmodule

// File: rtl/sertx_chan_chk.sv
module sertx_chan_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_data_en,
    input logic dma_wr,
    input logic clr_empty,
    input logic port_dir,
    input logic port_val,
    input logic txd,
    input logic empty_flag,
    input logic end_flag,
    input logic txi_req
);
    assert_mark_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_en) |=> txd);

    assert_write_alone_no_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data_en && !clr_empty && !dma_wr && empty_flag) |=> (empty_flag && $stable(empty_flag)));

    assert_copy_starts_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(empty_flag) && tx_en) |-> !txd);

    assert_no_req_after_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_flag) |-> !txi_req);

    assert_engine_write_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && empty_flag) |=> !empty_flag);

    assert_disable_sets_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> end_flag);

    assert_break_low_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && port_dir && !port_val) |-> !txd);

endmodule

bind sertx_chan sertx_chan_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_data_en (wr_data_en),
    .dma_wr     (dma_wr),
    .clr_empty  (clr_empty),
    .port_dir   (port_dir),
    .port_val   (port_val),
    .txd        (txd),
    .empty_flag (empty_flag),
    .end_flag   (end_flag),
    .txi_req    (txi_req)
);

// File: tb/sertx_chan_tb_top.sv
module sertx_chan_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int TPB        = 16;
    localparam int BIT_CLKS   = TPB * 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b0;
    logic       tx_en = 1'b0, wr_data_en = 1'b0, dma_wr = 1'b0, clr_empty = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       port_dir = 1'b0, port_val = 1'b1;
    logic       txd, empty_flag, end_flag, txi_req;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    sertx_chan #(.BIT_TICKS(TPB), .DATA_BITS(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .tx_en(tx_en),
        .wr_data_en(wr_data_en), .dma_wr(dma_wr), .clr_empty(clr_empty),
        .wr_data(wr_data), .port_dir(port_dir), .port_val(port_val),
        .txd(txd), .empty_flag(empty_flag), .end_flag(end_flag), .txi_req(txi_req)
    );

    // Baud enable: one cycle in three
    int div = 0;
    always @(negedge clk) begin
        baud_tick <= (div == 2);
        div = (div == 2) ? 0 : div + 1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: mode 0 off, 1 marking frame, 2 waiting, 3 frame
    int         m_mode, m_tick, m_pos;
    logic [7:0] m_tdr, m_cur;
    bit         m_empty, m_end, bnd, fend, ld, from_frame;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_tick = 0; m_pos = 0; m_tdr = 0; m_cur = 0;
            m_empty = 1; m_end = 1;
        end else begin
            bnd = (m_mode != 0) && baud_tick && (m_tick == TPB - 1);
            fend = 0; ld = 0; from_frame = 0;
            if (!tx_en) begin
                m_mode = 0; m_tick = 0;
            end else if (m_mode == 0) begin
                m_mode = 1; m_tick = 0; m_pos = 0;
            end else begin
                if (baud_tick) m_tick = bnd ? 0 : m_tick + 1;
                if (bnd) begin
                    if (m_mode == 2) fend = 1;
                    else if (m_pos == 9) begin
                        fend = 1;
                        from_frame = (m_mode == 3);
                    end else m_pos++;
                end
                if (fend) begin
                    if (!m_empty) begin
                        ld = 1; m_cur = m_tdr; m_mode = 3; m_pos = 0;
                    end else m_mode = 2;
                end
            end
            if (dma_wr || wr_data_en) m_tdr = wr_data;
            if (ld) m_empty = 1;
            else if (clr_empty || dma_wr) m_empty = 0;
            if (!tx_en) m_end = 1;
            else if (from_frame && !ld) m_end = 1;
            else if (clr_empty || dma_wr) m_end = 0;
        end
    end

    function automatic bit exp_txd();
        bit line;
        if (m_mode == 3) line = (m_pos == 0) ? 1'b0 : (m_pos == 9) ? 1'b1 : m_cur[m_pos-1];
        else line = 1'b1;
        if (tx_en) return line;
        return port_dir ? port_val : 1'b1;
    endfunction

    // Per-clock comparison a quarter period after the edge
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n && !done) begin
            chk(txd === exp_txd(), cur_req, "txd", int'(txd), int'(exp_txd()));
            chk(empty_flag === m_empty, cur_req, "empty_flag", int'(empty_flag), int'(m_empty));
            chk(end_flag === m_end, cur_req, "end_flag", int'(end_flag), int'(m_end));
            chk(txi_req === (m_empty && tx_en), "R6", "txi_req", int'(txi_req), int'(m_empty && tx_en));
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_wr(input logic [7:0] d);
        @(negedge clk); wr_data = d; wr_data_en = 1'b1;
        @(negedge clk); wr_data_en = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_empty = 1'b1;
        @(negedge clk); clr_empty = 1'b0;
    endtask

    task automatic pulse_dma(input logic [7:0] d);
        @(negedge clk); wr_data = d; dma_wr = 1'b1;
        @(negedge clk); dma_wr = 1'b0;
    endtask

    task automatic wait_empty_rise();
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (empty_flag) break;
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; failures++;
        $display("FAIL watchdog run did not complete actual=0 expected=1");
        finish_run();
    end

    initial begin
        bit held;
        cyc(3);
        // R1 reset values
        chk(txd && empty_flag && end_flag && !txi_req, "R1", "reset outputs",
            int'({txd, empty_flag, end_flag, txi_req}), 4'b1110);
        rst_n = 1'b1;
        cyc(2);

        // R11 port owns the pin while disabled
        cur_req = "R11";
        @(negedge clk); port_dir = 1'b1; port_val = 1'b0;
        @(negedge clk);
        chk(txd == 1'b0, "R11", "port drives low", int'(txd), 0);
        port_dir = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R11", "released line", int'(txd), 1);

        // R2 marking frame then R4/R5 first byte
        cur_req = "R2";
        @(negedge clk); tx_en = 1'b1;
        pulse_wr(8'hA5);
        pulse_clr();
        cyc(9 * BIT_CLKS - 8);
        chk(txd == 1'b1 && empty_flag == 1'b0, "R2", "still marking",
            int'({txd, empty_flag}), 2'b10);
        cur_req = "R5";
        wait_empty_rise();
        chk(txd == 1'b0, "R4", "start bit at copy", int'(txd), 0);
        chk(txi_req == 1'b1, "R6", "request after copy", int'(txi_req), 1);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (end_flag) break;
        end
        chk(end_flag == 1'b1, "R8", "finished after stop", int'(end_flag), 1);

        // R3 write without clear
        cur_req = "R3";
        pulse_wr(8'h3C);
        cyc(24 * BIT_CLKS);
        chk(empty_flag && txd, "R3", "no start on write alone",
            int'({empty_flag, txd}), 2'b11);

        // R9 clear drops the finished flag
        cur_req = "R9";
        pulse_clr();
        chk(end_flag == 1'b0, "R9", "end cleared", int'(end_flag), 0);
        chk(txi_req == 1'b0, "R6", "no request while pending", int'(txi_req), 0);

        // R7 / R8 back-to-back engine writes
        cur_req = "R7";
        wait_empty_rise();
        pulse_dma(8'h81);
        chk(empty_flag == 1'b0, "R7", "engine write clears", int'(empty_flag), 0);
        cur_req = "R8";
        wait_empty_rise();
        chk(end_flag == 1'b0 && txd == 1'b0, "R8", "no gap between frames",
            int'({end_flag, txd}), 2'b00);
        pulse_dma(8'h7E);
        wait_empty_rise();
        chk(end_flag == 1'b0, "R8", "end held low back-to-back", int'(end_flag), 0);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (end_flag) break;
        end
        chk(end_flag == 1'b1, "R8", "end after last frame", int'(end_flag), 1);

        // R10 disable mid-frame
        cur_req = "R10";
        pulse_wr(8'h55);
        pulse_clr();
        wait_empty_rise();
        cyc(3 * BIT_CLKS);
        @(negedge clk); tx_en = 1'b0;
        @(negedge clk);
        chk(end_flag == 1'b1 && txd == 1'b1, "R10", "abandon frame",
            int'({end_flag, txd}), 2'b11);
        cyc(5);
        @(negedge clk); tx_en = 1'b1;
        cyc(5);
        chk(txd == 1'b1, "R10", "marking after re-enable", int'(txd), 1);
        cyc(12 * BIT_CLKS);

        // R11 / R12 break through the port
        cur_req = "R12";
        @(negedge clk); port_dir = 1'b1; port_val = 1'b0;
        @(negedge clk);
        chk(txd == 1'b1, "R11", "transmitter owns pin", int'(txd), 1);
        tx_en = 1'b0;
        held = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (txd !== 1'b0) held = 1'b0;
        end
        chk(held, "R12", "break held low", int'(held), 1);

        cyc(4);
        finish_run();
    end

endmodule